// File: doc/BRIEF.md
# Single-Shot Countdown Event Timer

This block is a down-counter used as the event source of a system tick. Software first turns on the run bit in the control word. It then writes a tick count into the value word, and that write arms one countdown. Each pulse on the tick-enable input takes one off the counter. When the count is used up, a pending flag is latched and the counter stops at zero without reloading. The interrupt line is a level signal: it is high when the pending flag and the interrupt enable bit are both set.

The run bit gates everything else. A value write has effect only while the run bit is already set. Changes to the interrupt enable bit and the clear request are taken only from a control write that also carries the run bit. A control write of 0x00 stops the countdown and freezes the counter. A control write of 0x11 drops the pending flag and leaves the interrupt disabled. Reading the value word returns the count that remains.

Top module: `oneshot_tick_timer`

## Requirements
- R1: After reset the interrupt is low, the control word reads 0x00000000 and the value word reads 0.
- R2: A write to offset 0x40 sets the run bit from data bit 0. When data bit 0 is 1, it also sets interrupt enable from data bit 1. A read of offset 0x40 returns the run bit in bit 0, interrupt enable in bit 1, and 0 in every other bit, including bit 4.
- R3: A write to offset 0x44 while the run bit is 1 loads the written count into the counter and arms it. A read of offset 0x44 then returns that count.
- R4: A write to offset 0x44 while the run bit is 0 is ignored, and the counter keeps its previous value.
- R5: While the run bit is 1 and the counter is armed with a nonzero count, each clock with tick_en high lowers the count by exactly one. Clocks with tick_en low leave the count unchanged.
- R6: On the clock edge after an armed counter reads zero with the run bit set, the pending flag is set and the countdown stops. Further ticks leave the count at zero with no wrap.
- R7: irq is high exactly while the pending flag is set and interrupt enable is 1. A pending flag that is masked stays latched, and irq rises as soon as interrupt enable is set.
- R8: A control write with bit 4 and bit 0 both set (0x11) clears the pending flag and leaves interrupt enable at 0.
- R9: A control write of 0 stops the countdown: the counter holds its value under ticks. Setting the run bit again resumes counting from the held value.
- R10: A control write whose bit 0 is 0 leaves interrupt enable and the pending flag unchanged, whatever bits 1 and 4 hold.
- R11: When a value write and a tick pulse fall on the same clock, the written count is loaded and that tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle count pulse |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the countdown in several ways, and each one separates a different fault:
- Sparse tick pulses separated by idle clocks show whether the counter moves only on a tick.
- Counting down from a small count to zero places the interrupt rise on a single, exact clock edge.
- Extra ticks after the count reaches zero would expose a wrap.
- A count written on the same clock as a tick shows whether the load wins that clock.

The gating rules are checked by stimulus that should have no effect, followed by reads of the register or the interrupt line. Three such cases are used: a value write with the run bit off, a control write that carries interrupt bits without the run bit, and ticks while the timer is stopped. A last case masks and then unmasks a pending expiry, which separates a latched flag from a one-cycle pulse.

// File: rtl/ost_pkg.sv
package ost_pkg;

    // Bit positions inside the control word
    localparam int RUN_BIT   = 0;
    localparam int IEN_BIT   = 1;
    localparam int CLR_BIT   = 4;
    localparam int CTRL_BITS = 32;

    typedef struct packed {
        logic irq_en;
        logic run;
    } ctrl_t;

    function automatic logic [CTRL_BITS-1:0] ctrl_word(ctrl_t c);
        logic [CTRL_BITS-1:0] w;
        w          = '0;
        w[RUN_BIT] = c.run;
        w[IEN_BIT] = c.irq_en;
        return w;
    endfunction

endpackage

// File: rtl/ost_ctrl_reg.sv
module ost_ctrl_reg
    import ost_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctrl_wr,
    input  logic  d_run,
    input  logic  d_ien,
    input  logic  d_clr,
    output ctrl_t ctrl_q,
    output logic  clr_req
);

    // Interrupt bits are only taken when the same write carries the run bit
    assign clr_req = ctrl_wr && d_run && d_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run <= d_run;
            if (d_run) begin
                // a clear request also leaves the interrupt disabled
                ctrl_q.irq_en <= d_ien && !d_clr;
            end
        end
    end

endmodule

// File: rtl/ost_countdown.sv
module ost_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_zero;
    logic step;

    assign at_zero = (count == '0);
    assign expire  = run && armed && at_zero && !load;
    assign step    = run && armed && tick && !at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
        end else if (load) begin
            count <= load_val;
            armed <= 1'b1;
        end else if (expire) begin
            armed <= 1'b0;
        end else if (step) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/ost_irq_gen.sv
module ost_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clear,
    input  logic irq_en,
    output logic irq
);

    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else if (expire) begin
            pending_q <= 1'b1;
        end else if (clear) begin
            pending_q <= 1'b0;
        end
    end

    assign irq = pending_q && irq_en;

endmodule

// File: rtl/oneshot_tick_timer.sv
module oneshot_tick_timer
    import ost_pkg::*;
#(
    parameter int                 DATA_W     = 32,
    parameter int                 ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR  = ADDR_W'('h40),
    parameter logic [ADDR_W-1:0]  VALUE_ADDR = ADDR_W'('h44)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic              clr_req;
    logic              ctrl_wr;
    logic              value_wr;
    logic [DATA_W-1:0] count_q;
    logic              armed_q;
    logic              expire;

    assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
    assign value_wr = bus_wr && (bus_addr == VALUE_ADDR) && ctrl_q.run;

    ost_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .d_run   (bus_wdata[RUN_BIT]),
        .d_ien   (bus_wdata[IEN_BIT]),
        .d_clr   (bus_wdata[CLR_BIT]),
        .ctrl_q  (ctrl_q),
        .clr_req (clr_req)
    );

    ost_countdown #(.CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .load     (value_wr),
        .load_val (bus_wdata),
        .tick     (tick_en),
        .count    (count_q),
        .armed    (armed_q),
        .expire   (expire)
    );

    ost_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .clear  (clr_req),
        .irq_en (ctrl_q.irq_en),
        .irq    (irq)
    );

    always_comb begin
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata = DATA_W'(ctrl_word(ctrl_q));
        end else if (bus_addr == VALUE_ADDR) begin
            bus_rdata = count_q;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'('h40),
    parameter logic [ADDR_W-1:0] VALUE_ADDR = ADDR_W'('h44)
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              run,
    input logic              irq_en,
    input logic              armed,
    input logic [DATA_W-1:0] count
);

    logic vwr;
    logic cwr;
    logic at_end;

    assign vwr    = bus_wr && (bus_addr == VALUE_ADDR);
    assign cwr    = bus_wr && (bus_addr == CTRL_ADDR);
    assign at_end = run && armed && (count == '0);

    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        (vwr && run) |=> (count == $past(bus_wdata)) && armed); // R3

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count)); // R4

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && armed && tick_en && (count != '0) && !vwr)
        |=> (count == $past(count) - {{(DATA_W-1){1'b0}}, 1'b1})); // R5

    AST_EXPIRY_FIRES: assert property (@(posedge clk) disable iff (rst)
        (at_end && irq_en && !vwr && !cwr) |=> irq); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && !vwr) |=> (count == '0)); // R6

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cwr && bus_wdata[0] && bus_wdata[4] && !at_end) |=> !irq); // R8

endmodule

bind oneshot_tick_timer ost_checker #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .VALUE_ADDR (VALUE_ADDR)
) u_ost_checker (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run       (ctrl_q.run),
    .irq_en    (ctrl_q.irq_en),
    .armed     (armed_q),
    .count     (count_q)
);

// File: tb/test_oneshot_tick_timer.sv
module test_oneshot_tick_timer;

    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_VAL  = 8'h44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    oneshot_tick_timer i_oneshot_tick_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_VAL, d);  check("R1 value", d, 32'h0);
    endtask

    task automatic t_gated_off();
        logic [31:0] d;
        wr(A_VAL, 32'd5);
        rd(A_VAL, d); check("R4 value write ignored", d, 32'h0);
        wr(A_CTRL, 32'h12);
        rd(A_CTRL, d); check("R10 ctrl without run", d, 32'h0);
    endtask

    task automatic t_countdown();
        logic [31:0] d;
        wr(A_CTRL, 32'h01);
        rd(A_CTRL, d); check("R2 run bit", d, 32'h1);
        wr(A_VAL, 32'd3);
        rd(A_VAL, d); check("R3 load", d, 32'd3);
        repeat (2) @(negedge clk);
        rd(A_VAL, d); check("R5 idle no change", d, 32'd3);
        pulse(1); rd(A_VAL, d); check("R5 step", d, 32'd2);
        pulse(2); rd(A_VAL, d); check("R5 reach zero", d, 32'd0);
        @(negedge clk);
        check("R7 masked", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h03);
        check("R7 unmask", {31'b0, irq}, 32'h1);
        rd(A_CTRL, d); check("R2 readback", d, 32'h3);
        pulse(3); rd(A_VAL, d); check("R6 no wrap", d, 32'd0);
        check("R7 level held", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(A_CTRL, 32'h11);
        check("R8 clear", {31'b0, irq}, 32'h0);
        rd(A_CTRL, d); check("R8 ien off", d, 32'h1);
        wr(A_CTRL, 32'h03);
        check("R8 pending gone", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_expiry_edge();
        wr(A_VAL, 32'd2);
        pulse(2);
        check("R6 not before edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R6 next edge", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_ignore_ctrl();
        logic [31:0] d;
        wr(A_CTRL, 32'h12);
        check("R10 pending kept", {31'b0, irq}, 32'h1);
        rd(A_CTRL, d); check("R10 ien kept", d, 32'h2);
        wr(A_CTRL, 32'h11);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        wr(A_VAL, 32'd4);
        pulse(1); rd(A_VAL, d); check("R9 pre", d, 32'd3);
        wr(A_CTRL, 32'h00);
        pulse(3); rd(A_VAL, d); check("R9 frozen", d, 32'd3);
        wr(A_CTRL, 32'h01);
        pulse(1); rd(A_VAL, d); check("R9 resume", d, 32'd2);
    endtask

    task automatic t_load_tick();
        logic [31:0] d;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_VAL; bus_wdata = 32'd9; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd(A_VAL, d); check("R11 load wins", d, 32'd9);
        pulse(1); rd(A_VAL, d); check("R11 then step", d, 32'd8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gated_off();
        t_countdown();
        t_clear();
        t_expiry_edge();
        t_ignore_ctrl();
        t_freeze();
        t_load_tick();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule